// File: doc/BRIEF.md
# Message Interrupt Pending Vector with Read-and-Clear

This block keeps a wide pending vector of message interrupts, one bit per interrupt number, and drives a one-bit summary flag that tells the exception logic whether any message interrupt is outstanding. Producers post an interrupt with a single-cycle set pulse that carries the interrupt number. Software consumes interrupts one at a time through a read port.

A read has a side effect. It picks the lowest-numbered pending bit, returns its number and clears that bit in the same clock edge, so a service loop drains the vector in ascending order. A read of an empty vector returns a sentinel word with only bit 31 set. The lowest-index search is a combinational priority encoder over the stored vector. The read result is registered and comes with a one-cycle valid strobe.

Top module: `msgvec_rdclr`

## Requirements
- R1: After reset the pending vector is empty, `msg_pend` is 0 and `rd_data_vld` is 0.
- R2: A cycle with `set_vld` high marks bit `set_idx` pending, and `msg_pend` reads 1 after that clock edge.
- R3: A cycle with `rd_req` high raises `rd_data_vld` for exactly the following cycle. When a bit was pending, `rd_data[7:0]` holds the lowest pending index and `rd_data[31:8]` is zero.
- R4: The read clears the bit it reports, so the next read reports the next-lowest pending index.
- R5: A read while no bit is pending returns `rd_data` = 32'h8000_0000, which has bit 31 set and an index field of zero.
- R6: A read that removes the only pending bit still returns that bit's index, and `msg_pend` reads 0 after that edge.
- R7: A read that leaves other bits pending keeps `msg_pend` at 1.
- R8: A set and a read-clear that target the same bit in the same cycle leave that bit pending.
- R9: A set of a different bit in the same cycle as a read is recorded, but the read result only considers bits that were pending before that cycle.
- R10: Setting a bit that is already pending records a single interrupt, and it is consumed by one read.
- R11: `rd_data` holds its last value in cycles without a read, including cycles with a set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Post an interrupt this cycle |
| set_idx | input | 8 | Number of the interrupt to post |
| rd_req | input | 1 | Read-and-clear request |
| rd_data_vld | output | 1 | Read result valid, one cycle after `rd_req` |
| rd_data | output | 32 | Lowest pending index, or the empty sentinel |
| msg_pend | output | 1 | Summary flag: at least one interrupt pending |

## Verification
The drain order is tested with interrupts posted out of order and spread across both ends of the index range (0, 5, 77, 200, 255). This shows that the encoder picks the lowest index and not the newest or the highest. An empty read is separated from a read of index 0 by the sentinel word. Reads that coincide with a set are tried with the same index and with a different index, which separates set-wins from clear-wins. The different-index case also shows that a concurrent set is not visible to that read. Duplicate sets and idle cycles after a read show that a repeat post does not count twice and that the result register holds its value.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;

   typedef enum logic [0:0] {
      ENC_SCAN    = 1'b0,
      ENC_ISOLATE = 1'b1
   } enc_variant_e;

endpackage

// File: rtl/msgvec_prienc.sv
module msgvec_prienc
   import msgvec_pkg::*;
#(
   parameter int unsigned  WIDTH   = 256,
   parameter enc_variant_e VARIANT = ENC_SCAN,
   localparam int unsigned IDX_W   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] req,
   output logic             hit,
   output logic [IDX_W-1:0] idx,
   output logic [WIDTH-1:0] onehot
);

   assign hit = |req;

   generate
      if (VARIANT == ENC_SCAN) begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = WIDTH - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
         assign onehot = hit ? (WIDTH'(1) << idx) : '0;
      end else begin : g_isolate
         assign onehot = req & (~req + WIDTH'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < WIDTH; i++) begin
               if (onehot[i]) idx = idx | IDX_W'(i);
            end
         end
      end
   endgenerate

   // R3: the reported index must be a pending bit, and the mask marks exactly it
   always_comb begin
      if (hit) begin
         assert_idx_pending_R3: assert (req[idx] && onehot[idx] && $onehot(onehot));
      end
   end

endmodule

// File: rtl/msgvec_store.sv
module msgvec_store #(
   parameter int unsigned  WIDTH = 256,
   localparam int unsigned IDX_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_vld,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             clr_vld,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] pend_q
);

   logic [WIDTH-1:0] set_mask;
   logic [WIDTH-1:0] pend_d;

   assign set_mask = set_vld ? (WIDTH'(1) << set_idx) : '0;
   // the set is OR-ed in after the clear, so a set wins over a clear of the same bit
   assign pend_d   = (pend_q & ~(clr_vld ? clr_mask : '0)) | set_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   // R2 / R8: a posted bit is pending after the edge, whatever the clear did
   assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_vld |=> pend_q[$past(set_idx)]);

   // R4: a read without a set removes exactly one pending bit
   assert_clear_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld && !set_vld && $onehot(clr_mask & pend_q))
      |=> ($countones(pend_q) + 1 == $past($countones(pend_q))));

endmodule

// File: rtl/msgvec_rdclr.sv
module msgvec_rdclr
   import msgvec_pkg::*;
#(
   parameter int unsigned  NUM_IRQ     = 256,
   parameter int unsigned  RD_W        = 32,
   parameter int unsigned  EMPTY_BIT   = 31,
   parameter enc_variant_e ENC_VARIANT = ENC_SCAN,
   localparam int unsigned IDX_W       = $clog2(NUM_IRQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_vld,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             rd_req,
   output logic             rd_data_vld,
   output logic [RD_W-1:0]  rd_data,
   output logic             msg_pend
);

   localparam logic [RD_W-1:0] EMPTY_WORD = RD_W'(1) << EMPTY_BIT;

   generate
      if (NUM_IRQ < 2) begin : g_chk_num
         $error("msgvec_rdclr: NUM_IRQ must be at least 2");
      end
      if (EMPTY_BIT >= RD_W || EMPTY_BIT < IDX_W) begin : g_chk_empty
         $error("msgvec_rdclr: EMPTY_BIT must lie above the index field and inside RD_W");
      end
   endgenerate

   logic [NUM_IRQ-1:0] pend_q;
   logic [NUM_IRQ-1:0] low_mask;
   logic [IDX_W-1:0]   low_idx;
   logic               any_pend;
   logic               last_gone;

   msgvec_prienc #(
      .WIDTH   (NUM_IRQ),
      .VARIANT (ENC_VARIANT)
   ) i_prienc (
      .req    (pend_q),
      .hit    (any_pend),
      .idx    (low_idx),
      .onehot (low_mask)
   );

   msgvec_store #(
      .WIDTH (NUM_IRQ)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vld  (set_vld),
      .set_idx  (set_idx),
      .clr_vld  (rd_req),
      .clr_mask (low_mask),
      .pend_q   (pend_q)
   );

   assign last_gone = rd_req && any_pend && ((pend_q & ~low_mask) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_pend <= 1'b0;
      end else if (set_vld) begin
         msg_pend <= 1'b1;
      end else if (last_gone) begin
         msg_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data_vld <= 1'b0;
         rd_data     <= '0;
      end else begin
         rd_data_vld <= rd_req;
         if (rd_req) begin
            rd_data <= any_pend ? {{(RD_W - IDX_W){1'b0}}, low_idx} : EMPTY_WORD;
         end
      end
   end

   assert_strobe_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_data_vld);

   assert_strobe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_data_vld);

   assert_empty_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && pend_q == '0) |=> (rd_data == EMPTY_WORD));

   assert_index_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && pend_q != '0) |=> (rd_data[RD_W-1:IDX_W] == '0));

   // R6 / R7: the summary flag follows the vector contents
   assert_flag_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pend == (pend_q != '0));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_data));

endmodule

// File: tb/test_msgvec_rdclr.sv
module test_msgvec_rdclr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_vld = 1'b0;
   logic [7:0]  set_idx = '0;
   logic        rd_req = 1'b0;
   logic        rd_data_vld;
   logic [31:0] rd_data;
   logic        msg_pend;

   int n_checks = 0;
   int n_fail   = 0;

   localparam logic [31:0] EMPTY = 32'h8000_0000;

   always #10 clk = ~clk;

   msgvec_rdclr i_msgvec_rdclr (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_vld     (set_vld),
      .set_idx     (set_idx),
      .rd_req      (rd_req),
      .rd_data_vld (rd_data_vld),
      .rd_data     (rd_data),
      .msg_pend    (msg_pend)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic sv, input logic [7:0] si, input logic rd);
      set_vld = sv;
      set_idx = si;
      rd_req  = rd;
      @(posedge clk);
      @(negedge clk);
      set_vld = 1'b0;
      set_idx = '0;
      rd_req  = 1'b0;
   endtask

   task automatic read_expect(input string req, input logic [31:0] exp);
      step(1'b0, 8'd0, 1'b1);
      check({req, " strobe"}, 32'(rd_data_vld), 32'd1);
      check(req, rd_data, exp);
   endtask

   task automatic t_reset;
      check("R1 msg_pend", 32'(msg_pend), 32'd0);
      check("R1 rd_data_vld", 32'(rd_data_vld), 32'd0);
      read_expect("R1 empty after reset", EMPTY);
   endtask

   task automatic t_ordered;
      step(1'b1, 8'd200, 1'b0);
      check("R2 flag after set", 32'(msg_pend), 32'd1);
      check("R3 no strobe without read", 32'(rd_data_vld), 32'd0);
      step(1'b1, 8'd5, 1'b0);
      step(1'b1, 8'd77, 1'b0);
      step(1'b1, 8'd255, 1'b0);
      step(1'b1, 8'd0, 1'b0);
      read_expect("R3 lowest is 0", 32'd0);
      check("R7 flag kept", 32'(msg_pend), 32'd1);
      read_expect("R4 next is 5", 32'd5);
      read_expect("R4 next is 77", 32'd77);
      read_expect("R4 next is 200", 32'd200);
      check("R7 flag kept before last", 32'(msg_pend), 32'd1);
      read_expect("R6 last index 255", 32'd255);
      check("R6 flag dropped", 32'(msg_pend), 32'd0);
      step(1'b0, 8'd0, 1'b0);
      check("R3 strobe one cycle", 32'(rd_data_vld), 32'd0);
   endtask

   task automatic t_empty;
      read_expect("R5 empty sentinel", EMPTY);
      check("R5 flag stays 0", 32'(msg_pend), 32'd0);
   endtask

   task automatic t_set_wins;
      step(1'b1, 8'd9, 1'b0);
      step(1'b1, 8'd9, 1'b1);
      check("R8 result of colliding read", rd_data, 32'd9);
      check("R8 flag stays", 32'(msg_pend), 32'd1);
      read_expect("R8 bit still pending", 32'd9);
      read_expect("R8 then empty", EMPTY);
   endtask

   task automatic t_concurrent;
      step(1'b1, 8'd40, 1'b0);
      step(1'b1, 8'd3, 1'b1);
      check("R9 read ignores new set", rd_data, 32'd40);
      check("R9 flag after", 32'(msg_pend), 32'd1);
      read_expect("R9 new bit recorded", 32'd3);
      check("R9 flag dropped", 32'(msg_pend), 32'd0);
   endtask

   task automatic t_duplicate;
      step(1'b1, 8'd12, 1'b0);
      step(1'b1, 8'd12, 1'b0);
      read_expect("R10 single record", 32'd12);
      check("R10 flag dropped", 32'(msg_pend), 32'd0);
      read_expect("R10 nothing left", EMPTY);
   endtask

   task automatic t_hold;
      step(1'b1, 8'd130, 1'b0);
      read_expect("R11 setup", 32'd130);
      step(1'b0, 8'd0, 1'b0);
      check("R11 hold idle", rd_data, 32'd130);
      step(1'b1, 8'd1, 1'b0);
      check("R11 hold during set", rd_data, 32'd130);
      read_expect("R11 read after hold", 32'd1);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ordered();
      t_empty();
      t_set_wins();
      t_concurrent();
      t_duplicate();
      t_hold();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule